// File: doc/BRIEF.md
# Power-Fail Memory Chip-Enable Gate

This block sits between a processor's active-low memory chip enable and an external static RAM. While the supply is good, the enable passes straight through. When the supply-good flag drops, the gate write-protects the memory by holding the enable inactive. An access that is already under way is not cut short. The enable is kept active until the access ends or until a bounded hold time runs out.

When the supply comes back, a recovery lockout of a set number of cycles must pass before the gate follows the processor again. If the supply drops during that lockout, the lockout starts over. A sticky flag records whether any protective hold was ended by the timer instead of by the access finishing. Only reset clears that flag.

All timing is counted in clock cycles. Supply failure is recognised at a clock edge. From that edge the gate is either holding or protecting.

Top module: `power_fail_ce_gate`

## Requirements
- R1: After reset `ce_n_o` is 1 and `hold_timeout_o` is 0. The gate then stays blocked until the supply is good and a full recovery lockout has run.
- R2: In normal operation `ce_n_o` equals `ce_n_i` in the same cycle, with no register in the path.
- R3: If `supply_ok_i` is 0 and `ce_n_i` is 1 at a clock edge in normal operation, `ce_n_o` is 1 from that edge on.
- R4: If `supply_ok_i` is 0 and `ce_n_i` is 0 at a clock edge in normal operation, a hold starts. During the hold `ce_n_o` follows `ce_n_i`. The first edge that sees `ce_n_i` at 1 ends the hold, and protection follows.
- R5: A hold in which `ce_n_i` stays 0 lasts exactly `HOLD_CYCLES` cycles. `ce_n_o` then goes to 1 and `hold_timeout_o` goes to 1.
- R6: `hold_timeout_o` is sticky until reset. A hold that ends because the access completed does not set it.
- R7: While protected, an edge that sees `supply_ok_i` at 1 starts recovery. `ce_n_o` stays 1 for `REC_CYCLES` cycles with the supply good, and then follows `ce_n_i` again.
- R8: If `supply_ok_i` drops during recovery, the gate returns to protection, and recovery later restarts from zero.
- R9: While protected or recovering, a falling edge on `ce_n_i` does not bring `ce_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable from the processor, active low |
| supply_ok_i | input | 1 | Supply-good flag, 1 when the supply is in tolerance |
| ce_n_o | output | 1 | Gated chip enable to the memory, active low |
| hold_timeout_o | output | 1 | Sticky flag: a hold was ended by the timer |

## Verification
A wrong internal mode shows at `ce_n_o` in the same cycle. A missed transition into protection leaves the output following a new falling enable at once. A lingering normal mode after recovery should have been blocking does the same. A hold or recovery counter that is off by one moves the release or re-enable edge by one cycle, so it is only seen at the exact cycle of that edge. That is why the bench compares the output on every cycle against a model, instead of at a few milestones. A sticky flag that is set on the wrong kind of hold ending shows on `hold_timeout_o` one edge after the hold ends, and stays visible for the rest of the run.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_HOLD    = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfg_state_e;
endpackage

// File: rtl/pfg_cycle_cnt.sv
module pfg_cycle_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R5
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
#(
  parameter int HOLD_CYCLES = 250,
  parameter int REC_CYCLES  = 5,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_n_i,
  input  logic             supply_ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output pfg_state_e       state_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CYCLES - 1);

  pfg_state_e state_q, state_d;
  logic       timeout_q, set_timeout;

  always_comb begin
    state_d     = state_q;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    set_timeout = 1'b0;
    unique case (state_q)
      ST_NORMAL: if (!supply_ok_i) begin
        cnt_clr_o = 1'b1;
        state_d   = ce_n_i ? ST_PROTECT : ST_HOLD;
      end
      ST_HOLD: begin
        if (ce_n_i) state_d = ST_PROTECT;
        else if (cnt_i == HOLD_LAST) begin
          state_d     = ST_PROTECT;
          set_timeout = 1'b1;
        end else cnt_inc_o = 1'b1;
      end
      ST_PROTECT: if (supply_ok_i) begin
        cnt_clr_o = 1'b1;
        state_d   = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!supply_ok_i)           state_d = ST_PROTECT;
        else if (cnt_i == REC_LAST) state_d = ST_NORMAL;
        else                        cnt_inc_o = 1'b1;
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PROTECT;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_timeout) timeout_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign timeout_o = timeout_q;

  // R6
  timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_q |=> timeout_q);
  // R5
  hold_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (cnt_i <= HOLD_LAST));
  // R7
  rec_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER) |-> (cnt_i <= REC_LAST));
  // R7
  normal_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER && state_d == ST_NORMAL) |-> supply_ok_i);
  // R8
  rec_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER && !supply_ok_i) |=> (state_q == ST_PROTECT));
endmodule

// File: rtl/power_fail_ce_gate.sv
module power_fail_ce_gate
  import pfg_pkg::*;
#(
  parameter int HOLD_CYCLES = 250,
  parameter int REC_CYCLES  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic supply_ok_i,
  output logic ce_n_o,
  output logic hold_timeout_o
);
  localparam int MAX_CYC = (HOLD_CYCLES > REC_CYCLES) ? HOLD_CYCLES : REC_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  pfg_state_e       state;

  pfg_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  pfg_fsm #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .REC_CYCLES  (REC_CYCLES),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_n_i      (ce_n_i),
    .supply_ok_i (supply_ok_i),
    .cnt_i       (cnt),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .state_o     (state),
    .timeout_o   (hold_timeout_o)
  );

  // pass-through only in normal mode or while an access is held open
  assign ce_n_o = (state == ST_NORMAL || state == ST_HOLD) ? ce_n_i : 1'b1;

  // R4
  low_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_o |-> !ce_n_i);
  // R9
  no_reenable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PROTECT) |=> (ce_n_o || state == ST_NORMAL));
  // R3
  force_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_NORMAL && !supply_ok_i && ce_n_i) |=> ce_n_o);
endmodule

// File: tb/tb_power_fail_ce_gate.sv
`timescale 1ns/1ps
module tb_power_fail_ce_gate;
  localparam int HOLD = 8;
  localparam int REC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic ok = 1'b0;
  logic ce_n_o, to_o;

  int n_cmp = 0;
  int n_bad = 0;
  string req = "R1";
  bit done = 1'b0;

  // reference: mode 0 pass, 1 holding, 2 blocked, 3 lockout
  int  m_mode = 2;
  int  m_cnt  = 0;
  bit  m_to   = 1'b0;

  always #10 clk = ~clk;

  power_fail_ce_gate #(.HOLD_CYCLES(HOLD), .REC_CYCLES(REC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .supply_ok_i(ok),
    .ce_n_o(ce_n_o), .hold_timeout_o(to_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_cnt = 0; m_to = 1'b0;
    end else begin
      if (m_mode == 0) begin
        if (!ok) begin m_cnt = 0; m_mode = ce_n ? 2 : 1; end
      end else if (m_mode == 1) begin
        if (ce_n) m_mode = 2;
        else if (m_cnt + 1 >= HOLD) begin m_mode = 2; m_to = 1'b1; end
        else m_cnt++;
      end else if (m_mode == 2) begin
        if (ok) begin m_cnt = 0; m_mode = 3; end
      end else begin
        if (!ok) m_mode = 2;
        else if (m_cnt + 1 >= REC) m_mode = 0;
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    logic exp_ce;
    exp_ce = (m_mode <= 1) ? ce_n : 1'b1;
    n_cmp++;
    if (ce_n_o !== exp_ce) begin
      n_bad++;
      $display("FAIL %s ce_n_o actual=%b expected=%b t=%0t", req, ce_n_o, exp_ce, $time);
    end
    n_cmp++;
    if (to_o !== m_to) begin
      n_bad++;
      $display("FAIL %s hold_timeout_o actual=%b expected=%b t=%0t", req, to_o, m_to, $time);
    end
  end

  task automatic drive(input logic c, input logic s, input int cycles);
    ce_n = c; ok = s;
    repeat (cycles) @(posedge clk);
    #2;
  endtask

  task automatic direct(input string r, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s direct actual=%b expected=%b t=%0t", r, act, exp, $time);
    end
  endtask

  initial begin
    #5;
    req = "R1"; direct("R1", ce_n_o, 1'b1); direct("R1", to_o, 1'b0);
    #40 rst_n = 1'b1;
    @(posedge clk); #2;
    drive(1'b0, 1'b0, 3);
    direct("R1", ce_n_o, 1'b1);
    req = "R7"; drive(1'b0, 1'b1, REC - 1);
    direct("R7", ce_n_o, 1'b1);
    drive(1'b0, 1'b1, 2);
    req = "R2";
    for (int i = 0; i < 6; i++) begin
      drive(i[0], 1'b1, 1);
      direct("R2", ce_n_o, i[0]);
    end
    req = "R3"; drive(1'b1, 1'b0, 2);
    req = "R9"; drive(1'b0, 1'b0, 3);
    direct("R9", ce_n_o, 1'b1);
    drive(1'b0, 1'b1, 2);
    direct("R9", ce_n_o, 1'b1);
    drive(1'b1, 1'b1, REC + 1);
    req = "R4"; drive(1'b0, 1'b1, 1); drive(1'b0, 1'b0, 3);
    direct("R4", ce_n_o, 1'b0);
    drive(1'b1, 1'b0, 1); drive(1'b0, 1'b0, 2);
    direct("R4", ce_n_o, 1'b1);
    req = "R6"; direct("R6", to_o, 1'b0);
    drive(1'b1, 1'b1, REC + 2);
    req = "R5"; drive(1'b0, 1'b1, 1); drive(1'b0, 1'b0, HOLD + 3);
    direct("R5", ce_n_o, 1'b1); direct("R5", to_o, 1'b1);
    req = "R8"; drive(1'b0, 1'b1, REC - 1); drive(1'b0, 1'b0, 1);
    drive(1'b0, 1'b1, REC - 1);
    direct("R8", ce_n_o, 1'b1);
    drive(1'b0, 1'b1, 2);
    req = "R6"; drive(1'b1, 1'b1, 2); drive(1'b0, 1'b1, 2);
    direct("R6", to_o, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule